// File: doc/BRIEF.md
# Slot-Mapped Two-Group Interrupt Controller

This block gathers fifteen peripheral interrupt requests, gates each with a per-source enable, and presents the gated vector as a status word that software can read at any time. Sources 1 and 2 are edge-captured into sticky pending bits that only software clears. Sources 3 to 15 are level-sensitive and follow their inputs.

Priority is not tied to source numbers. Fifteen ordered priority slots each name a source and choose one of two groups, fast or normal. Slot 1 is the most urgent. Each slot takes part in arbitration only while its own enable bit is set. Each group is arbitrated on its own. The winner's source number is held in a per-group in-service register, and a request line goes to the processor. An active fast request masks the normal request line.

A simple single-cycle register bus gives write-1-to-set and write-1-to-clear access to both enable vectors, write access to the slots, a sticky clear, and reads of everything.

Top module: `irq_slot_ctrl`

## Requirements
- R1: Address 0 reads the status word. Bit n (1..15) is source n's pending state ANDed with its source enable, and bit 0 reads 0. For sources 3..15 the pending state is the input level in the same cycle.
- R2: Source enables are set by writing 1s to address 1 and cleared by writing 1s to address 2. Zero bits leave the enable unchanged. Address 1 reads the enable vector, bit n being source n. Address 2 and address 4 read 0.
- R3: Slot enables are set by writing 1s to address 3 and cleared by writing 1s to address 4. Bit n is slot n. Address 3 reads the vector.
- R4: Slot n (1..15) sits at address 7+n. Bits [3:0] hold the source index and bit 4 holds the group (1 = fast, 0 = normal). The slot reads back as written.
- R5: Sources 1 and 2 become pending on a rising input edge. They stay pending after the input falls until a write to address 5 with bit 1 (source 1) or bit 2 (source 2) set.
- R6: If a new rising edge of source 1 or 2 lands in the same cycle as its clear write, the source stays pending.
- R7: Address 6 reads the fast in-service number and address 7 the normal one. Each holds the source index of the lowest-numbered enabled slot of that group whose source has its status bit set. It is updated one clock after the status changes.
- R8: When no enabled slot of a group matches a set status bit, that group's in-service register reads 0 and its request is low. An index of 0 never matches.
- R9: fast_req_o is high exactly when the fast in-service value is non-zero. norm_req_o is high when the normal in-service value is non-zero and fast_req_o is low.
- R10: After reset, all enables, slots, sticky bits and in-service values are 0 and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 15 | Peripheral requests, bit n = source n (numbered 1..15) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| fast_req_o | output | 1 | Fast-group request to the processor |
| norm_req_o | output | 1 | Normal-group request to the processor, masked by fast |

## Verification
The hardest situation to reach from the ports is a sticky source whose new rising edge arrives in the very cycle that software writes its clear. The bench drives the input edge and the clear write on the same clock, then reads the status word. A second hard case is two slots of different groups that point at the same source, or a high slot that names an absent source while a lower slot names a pending one. Directed slot programming covers these cases, followed by a long run of random requests and random register writes. In every cycle that run is compared against a behavioural model.

// File: rtl/irq_slot_pkg.sv
package irq_slot_pkg;
    localparam int NSRC    = 15;
    localparam int NSLOT   = 15;
    localparam int IDW     = 4;
    localparam int DW      = 16;
    localparam int AW      = 5;
    localparam int NSTICKY = 2;

    localparam logic [AW-1:0] A_STATUS   = 5'd0;
    localparam logic [AW-1:0] A_SEN_SET  = 5'd1;
    localparam logic [AW-1:0] A_SEN_CLR  = 5'd2;
    localparam logic [AW-1:0] A_PEN_SET  = 5'd3;
    localparam logic [AW-1:0] A_PEN_CLR  = 5'd4;
    localparam logic [AW-1:0] A_SRC_CLR  = 5'd5;
    localparam logic [AW-1:0] A_ISR_FAST = 5'd6;
    localparam logic [AW-1:0] A_ISR_NORM = 5'd7;
    localparam int            SLOT_BASE  = 7;

    typedef struct packed {
        logic           fast;
        logic [IDW-1:0] idx;
    } slot_t;
endpackage

// File: rtl/irq_src_front.sv
module irq_src_front #(
    parameter int NSRC    = 15,
    parameter int NSTICKY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     src_i,
    input  logic [NSRC:1]     en_i,
    input  logic [NSTICKY:1]  clr_i,
    output logic [NSRC:1]     status_o
);
    typedef struct packed {
        logic [NSTICKY:1] prev;
        logic [NSTICKY:1] sticky;
    } front_t;

    front_t d, q;
    logic [NSRC:1] pend;

    always_comb begin
        d        = q;
        d.prev   = src_i[NSTICKY:1];
        d.sticky = (q.sticky & ~clr_i) | (src_i[NSTICKY:1] & ~q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar k = 1; k <= NSRC; k++) begin : g_pend
        if (k <= NSTICKY) begin : g_sticky
            assign pend[k] = q.sticky[k];
        end else begin : g_level
            assign pend[k] = src_i[k];
        end
    end

    assign status_o = pend & en_i;

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(q.sticky) & ~$past(clr_i) & ~q.sticky) == '0));

    for (genvar k = 1; k <= NSTICKY; k++) begin : g_chk
        // R6
        edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_i[k]) |=> q.sticky[k]);
    end
endmodule

// File: rtl/irq_group_arb.sv
module irq_group_arb
    import irq_slot_pkg::*;
#(
    parameter int NSRC     = 15,
    parameter int NSLOT    = 15,
    parameter bit GRP_FAST = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC:1]         status_i,
    input  logic [NSLOT:1]        slot_en_i,
    input  slot_t [NSLOT:1]       slots_i,
    output logic [IDW-1:0]        id_o,
    output logic                  req_o
);
    localparam int EXTW = 1 << IDW;

    typedef struct packed {
        logic [IDW-1:0] id;
        logic           req;
    } arb_t;

    arb_t d, q;
    logic [EXTW-1:0] stat_ext;
    logic            hit;
    logic [IDW-1:0]  pick;

    always_comb begin
        stat_ext           = '0;
        stat_ext[NSRC:1]   = status_i;
    end

    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int s = 1; s <= NSLOT; s++) begin
            if (!hit && slot_en_i[s] && (slots_i[s].fast == GRP_FAST) &&
                stat_ext[slots_i[s].idx]) begin
                hit  = 1'b1;
                pick = slots_i[s].idx;
            end
        end
        d     = q;
        d.req = hit;
        d.id  = hit ? pick : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign id_o  = q.id;
    assign req_o = q.req;

    logic [EXTW-1:0] stat_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_seen_q <= '0;
        else        stat_seen_q <= stat_ext;
    end

    // R8
    req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.req |-> stat_seen_q[q.id]);
endmodule

// File: rtl/irq_slot_ctrl.sv
module irq_slot_ctrl
    import irq_slot_pkg::*;
#(
    parameter int P_NSRC    = NSRC,
    parameter int P_NSLOT   = NSLOT,
    parameter int P_NSTICKY = NSTICKY
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_NSRC:1]     src_req_i,
    input  logic                bus_wr_i,
    input  logic [AW-1:0]       bus_addr_i,
    input  logic [DW-1:0]       bus_wdata_i,
    output logic [DW-1:0]       bus_rdata_o,
    output logic                fast_req_o,
    output logic                norm_req_o
);
    localparam int NGRP = 2;

    typedef struct packed {
        logic [P_NSRC:1]        sen;
        logic [P_NSLOT:1]       pen;
        slot_t [P_NSLOT:1]      slots;
    } regs_t;

    regs_t d, q;
    logic [P_NSTICKY:1] clr;
    logic [P_NSRC:1]    status;
    logic [IDW-1:0]     gid  [NGRP];
    logic [NGRP-1:0]    greq;
    logic               unused_bit0;

    assign unused_bit0 = bus_wdata_i[0];

    always_comb begin
        d   = q;
        clr = '0;
        if (bus_wr_i) begin
            case (bus_addr_i)
                A_SEN_SET: d.sen = q.sen | bus_wdata_i[P_NSRC:1];
                A_SEN_CLR: d.sen = q.sen & ~bus_wdata_i[P_NSRC:1];
                A_PEN_SET: d.pen = q.pen | bus_wdata_i[P_NSLOT:1];
                A_PEN_CLR: d.pen = q.pen & ~bus_wdata_i[P_NSLOT:1];
                A_SRC_CLR: clr   = bus_wdata_i[P_NSTICKY:1];
                default: ;
            endcase
            for (int s = 1; s <= P_NSLOT; s++) begin
                if (bus_addr_i == AW'(SLOT_BASE + s))
                    d.slots[s] = slot_t'(bus_wdata_i[IDW:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    irq_src_front #(.NSRC(P_NSRC), .NSTICKY(P_NSTICKY)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_req_i),
        .en_i     (q.sen),
        .clr_i    (clr),
        .status_o (status)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_arb
        irq_group_arb #(.NSRC(P_NSRC), .NSLOT(P_NSLOT), .GRP_FAST(g == 0)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .status_i  (status),
            .slot_en_i (q.pen),
            .slots_i   (q.slots),
            .id_o      (gid[g]),
            .req_o     (greq[g])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_STATUS:   bus_rdata_o[P_NSRC:1]  = status;
            A_SEN_SET:  bus_rdata_o[P_NSRC:1]  = q.sen;
            A_PEN_SET:  bus_rdata_o[P_NSLOT:1] = q.pen;
            A_ISR_FAST: bus_rdata_o[IDW-1:0]   = gid[0];
            A_ISR_NORM: bus_rdata_o[IDW-1:0]   = gid[1];
            default: ;
        endcase
        for (int s = 1; s <= P_NSLOT; s++) begin
            if (bus_addr_i == AW'(SLOT_BASE + s))
                bus_rdata_o[IDW:0] = q.slots[s];
        end
    end

    assign fast_req_o = greq[0];
    assign norm_req_o = greq[1] & ~greq[0];

    // R2
    sen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == A_SEN_SET) |=>
        ((q.sen & $past(bus_wdata_i[P_NSRC:1])) == $past(bus_wdata_i[P_NSRC:1])));

    // R2
    sen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == A_SEN_CLR) |=>
        ((q.sen & $past(bus_wdata_i[P_NSRC:1])) == '0));

    // R3
    pen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == A_PEN_CLR) |=>
        ((q.pen & $past(bus_wdata_i[P_NSLOT:1])) == '0));

    // R9
    fast_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (greq[0] && greq[1]) |-> (fast_req_o && !norm_req_o));
endmodule

// File: tb/irq_slot_ctrl_tb_top.sv
module irq_slot_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] src_req = '0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        fast_req, norm_req;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string phase = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_slot_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req_i   (src_req),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .fast_req_o  (fast_req),
        .norm_req_o  (norm_req)
    );

    // behavioural reference state
    logic [15:1] m_sen = '0, m_pen = '0;
    logic [2:1]  m_sticky = '0, m_prev = '0;
    int          m_idx [16];
    bit          m_typ [16];
    int          m_fid = 0, m_nid = 0;

    function automatic logic [15:1] m_status();
        logic [15:1] st;
        for (int k = 1; k <= 15; k++) begin
            logic p;
            p = (k <= 2) ? m_sticky[k] : src_req[k];
            st[k] = p & m_sen[k];
        end
        return st;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [4:0] a);
        logic [15:0] r;
        r = '0;
        if (a == 0) r[15:1] = m_status();
        else if (a == 1) r[15:1] = m_sen;
        else if (a == 3) r[15:1] = m_pen;
        else if (a == 6) r = 16'(m_fid);
        else if (a == 7) r = 16'(m_nid);
        else if (a >= 8 && a <= 22) r = 16'((int'(m_typ[a-7]) << 4) | m_idx[a-7]);
        return r;
    endfunction

    function automatic string addr_tag(input logic [4:0] a);
        if (a == 0) return "R1";
        if (a == 1 || a == 2) return "R2";
        if (a == 3 || a == 4) return "R3";
        if (a == 6 || a == 7) return "R7";
        if (a >= 8 && a <= 22) return "R4";
        return "R5";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sen = '0; m_pen = '0; m_sticky = '0; m_prev = '0;
            m_fid = 0; m_nid = 0;
            for (int s = 0; s < 16; s++) begin m_idx[s] = 0; m_typ[s] = 0; end
        end else begin
            logic [15:1] st;
            int nf, nn;
            st = m_status();
            nf = 0; nn = 0;
            for (int s = 1; s <= 15; s++) begin
                if (m_pen[s] && m_idx[s] != 0 && st[m_idx[s]]) begin
                    if (m_typ[s] && nf == 0) nf = m_idx[s];
                    if (!m_typ[s] && nn == 0) nn = m_idx[s];
                end
            end
            m_fid = nf; m_nid = nn;
            for (int k = 1; k <= 2; k++) begin
                logic clr;
                clr = bus_wr && bus_addr == 5 && bus_wdata[k];
                m_sticky[k] = (m_sticky[k] && !clr) || (src_req[k] && !m_prev[k]);
                m_prev[k] = src_req[k];
            end
            if (bus_wr) begin
                case (bus_addr)
                    1: m_sen = m_sen | bus_wdata[15:1];
                    2: m_sen = m_sen & ~bus_wdata[15:1];
                    3: m_pen = m_pen | bus_wdata[15:1];
                    4: m_pen = m_pen & ~bus_wdata[15:1];
                    default: ;
                endcase
                if (bus_addr >= 8 && bus_addr <= 22) begin
                    m_idx[bus_addr-7] = int'(bus_wdata[3:0]);
                    m_typ[bus_addr-7] = bus_wdata[4];
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic ef, en;
            logic [15:0] er;
            ef = (m_fid != 0);
            en = (m_nid != 0) && !ef;
            er = exp_rd(bus_addr);
            compared += 3;
            if (fast_req !== ef) begin
                mismatched++;
                $display("FAIL R9 [%s] fast_req got %b exp %b", phase, fast_req, ef);
            end
            if (norm_req !== en) begin
                mismatched++;
                $display("FAIL R9 [%s] norm_req got %b exp %b", phase, norm_req, en);
            end
            if (bus_rdata !== er) begin
                mismatched++;
                $display("FAIL %s [%s] addr %0d rdata got %h exp %h",
                         addr_tag(bus_addr), phase, bus_addr, bus_rdata, er);
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        step(); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        step(); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input int n);
        for (int i = 0; i < n; i++) begin step(); bus_addr = a; end
    endtask

    task automatic read_all();
        for (int a = 0; a <= 22; a++) begin step(); bus_addr = 5'(a); end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        // R10: reset state read back
        repeat (3) @(posedge clk);
        step(); rst_n = 1'b1;
        read_all();

        // R2 / R3: set and clear by bit
        phase = "R2";
        wr(1, 16'hFFFE); rd(1, 2);
        wr(2, 16'h00A4); rd(1, 2); rd(2, 1);
        phase = "R3";
        wr(3, 16'h0F0E); rd(3, 2);
        wr(4, 16'h0006); rd(3, 2); rd(4, 1);

        // R4: program slots
        phase = "R4";
        wr(8,  16'h0009);   // slot1 -> src9 normal
        wr(9,  16'h0013);   // slot2 -> src3 fast
        wr(10, 16'h0014);   // slot3 -> src4 fast
        wr(11, 16'h0001);   // slot4 -> src1 normal
        wr(12, 16'h0012);   // slot5 -> src2 fast
        wr(13, 16'h0000);   // slot6 -> index 0
        read_all();
        wr(1, 16'hFFFE);
        wr(3, 16'h003F);

        // R1: level sources follow inputs
        phase = "R1";
        step(); bus_addr = 0; src_req = 15'h0A50;
        rd(0, 2);
        step(); src_req = '0; rd(0, 2);

        // R7: priority by slot, not by number
        phase = "R7";
        step(); src_req[4] = 1'b1; rd(6, 2);
        step(); src_req[3] = 1'b1; rd(6, 2);
        step(); src_req[9] = 1'b1; rd(7, 2);
        // R9: fast masks normal
        phase = "R9";
        rd(7, 2);
        step(); src_req[3] = 1'b0; src_req[4] = 1'b0; rd(7, 3);
        // R8: no enabled match gives zero
        phase = "R8";
        wr(4, 16'h0002); rd(7, 3);
        wr(3, 16'h0002);
        step(); src_req = '0; rd(6, 3); rd(7, 2);

        // R5: sticky source 1 and 2
        phase = "R5";
        step(); src_req[1] = 1'b1; bus_addr = 0;
        step(); src_req[1] = 1'b0; rd(0, 3); rd(7, 2);
        step(); src_req[2] = 1'b1;
        step(); src_req[2] = 1'b0; rd(6, 3);
        wr(5, 16'h0002); rd(0, 3);
        wr(5, 16'h0004); rd(0, 2); rd(6, 2);

        // R6: new edge in the cycle of the clear
        phase = "R6";
        step(); bus_addr = 0; src_req[2] = 1'b1;
        step(); src_req[2] = 1'b0;
        step(); bus_wr = 1'b1; bus_addr = 5; bus_wdata = 16'h0004; src_req[2] = 1'b1;
        step(); bus_wr = 1'b0; bus_addr = 0;
        rd(0, 3);
        wr(5, 16'h0006); rd(0, 2);

        // mixed random traffic against the model
        phase = "R7 random";
        for (int i = 0; i < 4000; i++) begin
            step();
            src_req = 15'($urandom);
            if (($urandom % 4) == 0) begin
                bus_wr = 1'b1;
                bus_addr = 5'(1 + ($urandom % 22));
                bus_wdata = 16'($urandom);
            end else begin
                bus_wr = 1'b0;
                bus_addr = 5'($urandom % 23);
            end
        end
        step(); bus_wr = 1'b0;
        rd(6, 2);
        finish_run();
    end
endmodule